// File: doc/BRIEF.md
# UART FIFO Threshold Status Unit

This unit owns the transmit and receive byte queues of a UART and turns their fill levels into status flags and interrupt requests. The bus side writes bytes into the transmit queue and reads bytes out of the receive queue. The serial side pops bytes to send, and it delivers each received frame together with its stop-bit and parity results. Two 2-bit trigger codes set the fill level at which the transmit-space flag and the receive-data flag come up. A packed count word reports both fill levels at once.

Software clears a status bit in two steps: it reads the status word while the bit is 1, then writes a 0 to that bit. The two threshold flags are set again on the same clock edge if their fill-level condition still holds after the clear. A frame whose data bits and stop bit are all zero is treated as a line break. It raises the framing-error and break flags and puts the receiver in a break state. While that state lasts, frames are still accepted from the shifter but nothing enters the receive queue. The state ends when the line level returns high.

Top module: `uart_fifo_flags`

## Requirements
- R1: Status bit 0 (transmit space) is 1 one clock edge after the transmit count is at or below the level selected by the transmit trigger code: 00→8, 01→4, 10→2, 11→0 bytes.
- R2: Status bit 0 stays set when the count rises above the level. A read-1/write-0 clear leaves it at 1 if the count is still at or below the level, and at 0 otherwise.
- R3: Status bit 2 (receive data) is 1 one clock edge after the receive count is at or above the level selected by the receive trigger code: 00→1, 01→4, 10→8, 11→14 bytes.
- R4: Status bit 2 stays set when the count falls below the level. A read-1/write-0 clear leaves it at 1 if the count is still at or above the level, and at 0 otherwise.
- R5: The count word carries the transmit byte count in bits 15:8 and the receive byte count in bits 7:0.
- R6: A status bit is cleared only by a write of 0 to a bit that was read as 1 since the previous status write. Writing 1 has no effect, and a write without such a read has no effect.
- R7: A received frame with a 0 stop bit sets status bit 3 (framing error). A frame flagged with a parity error sets bit 4 (parity error). A frame with all data bits and the stop bit at 0 also sets bit 5 (break) and enters the break state.
- R8: In the break state, and for the break frame itself, no byte enters the receive queue. The state ends once the line input is sampled high, after which frames are queued again.
- R9: The transmit interrupt equals status bit 0 AND its enable, and the receive interrupt equals status bit 2 AND its enable, each registered one cycle later.
- R10: Status bit 1 (transmit end) is set when the transmit queue is empty and the shifter reports idle, and is cleared by a write into the transmit queue.
- R11: Each queue holds 16 bytes in first-in first-out order. A push into a full queue and a pop from an empty queue are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_tx_wr | input | 1 | Write strobe into the transmit queue |
| bus_tx_data | input | 8 | Byte written into the transmit queue |
| sh_tx_pop | input | 1 | Shifter takes the head byte of the transmit queue |
| sh_tx_data | output | 8 | Head byte of the transmit queue |
| sh_tx_idle | input | 1 | Shifter has no frame in flight |
| sh_rx_valid | input | 1 | A received frame is delivered this cycle |
| sh_rx_data | input | 8 | Data bits of the received frame |
| sh_rx_stop_ok | input | 1 | Stop bit of the frame was sampled high |
| sh_rx_par_err | input | 1 | Parity check of the frame failed |
| rx_line | input | 1 | Current receive line level |
| bus_rx_rd | input | 1 | Read strobe from the receive queue |
| bus_rx_data | output | 8 | Head byte of the receive queue |
| cfg_tx_trig | input | 2 | Transmit trigger code |
| cfg_rx_trig | input | 2 | Receive trigger code |
| cfg_tx_ie | input | 1 | Transmit interrupt enable |
| cfg_rx_ie | input | 1 | Receive interrupt enable |
| bus_sts_rd | input | 1 | Status word read strobe |
| bus_sts_wr | input | 1 | Status word write strobe |
| bus_sts_wdata | input | 6 | Status write data, 0 clears an armed bit |
| bus_sts_rdata | output | 6 | Status word |
| bus_cnt_rdata | output | 16 | Packed transmit and receive byte counts |
| tx_irq | output | 1 | Transmit interrupt request |
| rx_irq | output | 1 | Receive interrupt request |

## Verification
The hardest case to reach from the ports is a clear that lands at a fill level right next to a trigger boundary. Reaching it takes a status read, a status write and a known queue depth all at once, so the re-assertion case only shows up when the count sits exactly at the level. The stimulus therefore moves each queue one byte at a time, from empty to full and back, under every trigger code. After each step it samples the flag before a clear and again after a read-then-write clear. Pre-clear samples show the flag holding its state, and post-clear samples show whether the flag comes straight back.

// File: rtl/uft_pkg.sv
package uft_pkg;

    localparam int BYTE_W = 8;
    localparam int STAT_W = 6;

    localparam int BIT_TXE  = 0;
    localparam int BIT_TEND = 1;
    localparam int BIT_RXF  = 2;
    localparam int BIT_FER  = 3;
    localparam int BIT_PER  = 4;
    localparam int BIT_BRK  = 5;

    // Packed so that the last member is bit 0 of the status word.
    typedef struct packed {
        logic brk;
        logic per;
        logic fer;
        logic rxf;
        logic tend;
        logic txe;
    } stat_t;

    typedef enum logic {
        LINE_OK    = 1'b0,
        LINE_BREAK = 1'b1
    } line_st_e;

    typedef struct packed {
        logic              valid;
        logic [BYTE_W-1:0] data;
        logic              stop_ok;
        logic              par_err;
    } rx_frame_t;

    function automatic int unsigned tx_trig_level(input logic [1:0] code,
                                                  input int unsigned depth);
        case (code)
            2'b00:   return depth / 2;
            2'b01:   return depth / 4;
            2'b10:   return depth / 8;
            default: return 0;
        endcase
    endfunction

    function automatic int unsigned rx_trig_level(input logic [1:0] code,
                                                  input int unsigned depth);
        case (code)
            2'b00:   return 1;
            2'b01:   return depth / 4;
            2'b10:   return depth / 2;
            default: return depth - 2;
        endcase
    endfunction

endpackage

// File: rtl/uft_fifo.sv
module uft_fifo #(
    parameter  int W     = 8,
    parameter  int DEPTH = 16,
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic [W-1:0]  push_data,
    input  logic          pop,
    output logic [W-1:0]  head,
    output logic [CW-1:0] count
);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic          do_push, do_pop;

    assign do_push = push && (count != CW'(DEPTH));
    assign do_pop  = pop && (count != '0);
    assign head    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr] <= push_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) begin
                wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + AW'(1);
            end
            if (do_pop) begin
                rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + AW'(1);
            end
            case ({do_push, do_pop})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH)); // R11

    AST_FULL_DROP: assert property (@(posedge clk) disable iff (rst)
        (push && !pop && count == CW'(DEPTH)) |=> (count == CW'(DEPTH))); // R11

    AST_EMPTY_POP: assert property (@(posedge clk) disable iff (rst)
        (pop && !push && count == '0) |=> (count == '0)); // R11

endmodule

// File: rtl/uft_rx_gate.sv
module uft_rx_gate
    import uft_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  rx_frame_t frm,
    input  logic      line_level,
    output logic      push,
    output logic      fer_evt,
    output logic      per_evt,
    output logic      brk_evt,
    output logic      in_break
);

    line_st_e st_q, st_d;
    logic     brk_frame;

    assign brk_frame = frm.valid && (frm.data == '0) && !frm.stop_ok;

    always_comb begin
        st_d = st_q;
        if (brk_frame) begin
            st_d = LINE_BREAK;
        end else if (st_q == LINE_BREAK && line_level) begin
            st_d = LINE_OK;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= LINE_OK;
        end else begin
            st_q <= st_d;
        end
    end

    assign in_break = (st_q == LINE_BREAK);
    assign push     = frm.valid && !brk_frame && !in_break;
    assign fer_evt  = frm.valid && !frm.stop_ok;
    assign per_evt  = frm.valid && frm.par_err;
    assign brk_evt  = brk_frame && !in_break;

    AST_BRK_HOLD: assert property (@(posedge clk) disable iff (rst)
        (in_break && !line_level) |=> in_break); // R8

endmodule

// File: rtl/uft_flag_unit.sv
module uft_flag_unit
    import uft_pkg::*;
#(
    parameter  int DEPTH = 16,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CW-1:0]     tx_cnt,
    input  logic [CW-1:0]     rx_cnt,
    input  logic [1:0]        tx_code,
    input  logic [1:0]        rx_code,
    input  logic              tx_wr,
    input  logic              shift_idle,
    input  logic              fer_evt,
    input  logic              per_evt,
    input  logic              brk_evt,
    input  logic              sts_rd,
    input  logic              sts_wr,
    input  logic [STAT_W-1:0] sts_wdata,
    input  logic              tx_ie,
    input  logic              rx_ie,
    output stat_t             flags,
    output logic              tx_irq,
    output logic              rx_irq
);

    stat_t             flags_q, flags_d;
    logic [STAT_W-1:0] armed_q;
    logic [STAT_W-1:0] clr;
    logic [CW-1:0]     tx_lvl, rx_lvl;
    logic              tx_hit, rx_hit, tend_set;

    assign tx_lvl   = CW'(tx_trig_level(tx_code, DEPTH));
    assign rx_lvl   = CW'(rx_trig_level(rx_code, DEPTH));
    assign tx_hit   = (tx_cnt <= tx_lvl);
    assign rx_hit   = (rx_cnt >= rx_lvl);
    assign tend_set = (tx_cnt == '0) && shift_idle;

    // A bit may be cleared only if software saw it at 1 since the last write.
    assign clr = sts_wr ? (armed_q & ~sts_wdata) : '0;

    always_comb begin
        flags_d.txe  = tx_hit  || (flags_q.txe  && !clr[BIT_TXE]);
        flags_d.tend = !tx_wr && (tend_set || (flags_q.tend && !clr[BIT_TEND]));
        flags_d.rxf  = rx_hit  || (flags_q.rxf  && !clr[BIT_RXF]);
        flags_d.fer  = fer_evt || (flags_q.fer  && !clr[BIT_FER]);
        flags_d.per  = per_evt || (flags_q.per  && !clr[BIT_PER]);
        flags_d.brk  = brk_evt || (flags_q.brk  && !clr[BIT_BRK]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
            armed_q <= '0;
            tx_irq  <= 1'b0;
            rx_irq  <= 1'b0;
        end else begin
            flags_q <= flags_d;
            if (sts_wr) begin
                armed_q <= '0;
            end else if (sts_rd) begin
                armed_q <= armed_q | flags_q;
            end
            tx_irq <= flags_q.txe && tx_ie;
            rx_irq <= flags_q.rxf && rx_ie;
        end
    end

    assign flags = flags_q;

    AST_TXE_SET: assert property (@(posedge clk) disable iff (rst)
        tx_hit |=> flags_q.txe); // R1

    AST_RXF_SET: assert property (@(posedge clk) disable iff (rst)
        rx_hit |=> flags_q.rxf); // R3

    AST_NO_BLIND_CLR: assert property (@(posedge clk) disable iff (rst)
        (flags_q.fer && !armed_q[BIT_FER]) |=> flags_q.fer); // R6

    AST_TXIRQ_ON: assert property (@(posedge clk) disable iff (rst)
        (flags_q.txe && tx_ie) |=> tx_irq); // R9

    AST_RXIRQ_OFF: assert property (@(posedge clk) disable iff (rst)
        !rx_ie |=> !rx_irq); // R9

    AST_TEND_CLR: assert property (@(posedge clk) disable iff (rst)
        tx_wr |=> !flags_q.tend); // R10

endmodule

// File: rtl/uart_fifo_flags.sv
module uart_fifo_flags
    import uft_pkg::*;
#(
    parameter  int DEPTH       = 16,
    parameter  int CNT_FIELD_W = 8,
    localparam int CW          = $clog2(DEPTH + 1)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     bus_tx_wr,
    input  logic [BYTE_W-1:0]        bus_tx_data,
    input  logic                     sh_tx_pop,
    output logic [BYTE_W-1:0]        sh_tx_data,
    input  logic                     sh_tx_idle,
    input  logic                     sh_rx_valid,
    input  logic [BYTE_W-1:0]        sh_rx_data,
    input  logic                     sh_rx_stop_ok,
    input  logic                     sh_rx_par_err,
    input  logic                     rx_line,
    input  logic                     bus_rx_rd,
    output logic [BYTE_W-1:0]        bus_rx_data,
    input  logic [1:0]               cfg_tx_trig,
    input  logic [1:0]               cfg_rx_trig,
    input  logic                     cfg_tx_ie,
    input  logic                     cfg_rx_ie,
    input  logic                     bus_sts_rd,
    input  logic                     bus_sts_wr,
    input  logic [STAT_W-1:0]        bus_sts_wdata,
    output logic [STAT_W-1:0]        bus_sts_rdata,
    output logic [2*CNT_FIELD_W-1:0] bus_cnt_rdata,
    output logic                     tx_irq,
    output logic                     rx_irq
);

    logic [CW-1:0] tx_cnt, rx_cnt;
    logic          rx_push, fer_evt, per_evt, brk_evt, in_break;
    rx_frame_t     frm;
    stat_t         flags;

    assign frm = '{valid:   sh_rx_valid,
                   data:    sh_rx_data,
                   stop_ok: sh_rx_stop_ok,
                   par_err: sh_rx_par_err};

    uft_fifo #(.W(BYTE_W), .DEPTH(DEPTH)) u_tx_q (
        .clk       (clk),
        .rst       (rst),
        .push      (bus_tx_wr),
        .push_data (bus_tx_data),
        .pop       (sh_tx_pop),
        .head      (sh_tx_data),
        .count     (tx_cnt)
    );

    uft_rx_gate u_gate (
        .clk        (clk),
        .rst        (rst),
        .frm        (frm),
        .line_level (rx_line),
        .push       (rx_push),
        .fer_evt    (fer_evt),
        .per_evt    (per_evt),
        .brk_evt    (brk_evt),
        .in_break   (in_break)
    );

    uft_fifo #(.W(BYTE_W), .DEPTH(DEPTH)) u_rx_q (
        .clk       (clk),
        .rst       (rst),
        .push      (rx_push),
        .push_data (sh_rx_data),
        .pop       (bus_rx_rd),
        .head      (bus_rx_data),
        .count     (rx_cnt)
    );

    uft_flag_unit #(.DEPTH(DEPTH)) u_flags (
        .clk        (clk),
        .rst        (rst),
        .tx_cnt     (tx_cnt),
        .rx_cnt     (rx_cnt),
        .tx_code    (cfg_tx_trig),
        .rx_code    (cfg_rx_trig),
        .tx_wr      (bus_tx_wr),
        .shift_idle (sh_tx_idle),
        .fer_evt    (fer_evt),
        .per_evt    (per_evt),
        .brk_evt    (brk_evt),
        .sts_rd     (bus_sts_rd),
        .sts_wr     (bus_sts_wr),
        .sts_wdata  (bus_sts_wdata),
        .tx_ie      (cfg_tx_ie),
        .rx_ie      (cfg_rx_ie),
        .flags      (flags),
        .tx_irq     (tx_irq),
        .rx_irq     (rx_irq)
    );

    assign bus_sts_rdata = flags;
    assign bus_cnt_rdata = {CNT_FIELD_W'(tx_cnt), CNT_FIELD_W'(rx_cnt)};

    AST_BRK_NO_PUSH: assert property (@(posedge clk) disable iff (rst)
        in_break |=> (rx_cnt <= $past(rx_cnt))); // R8

    AST_BRK_FER: assert property (@(posedge clk) disable iff (rst)
        (sh_rx_valid && sh_rx_data == '0 && !sh_rx_stop_ok) |=> flags.fer); // R7

endmodule

// File: tb/tb_uart_fifo_flags.sv
module tb_uart_fifo_flags;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_tx_wr = 0;
    logic [7:0]  bus_tx_data = 0;
    logic        sh_tx_pop = 0;
    logic [7:0]  sh_tx_data;
    logic        sh_tx_idle = 1;
    logic        sh_rx_valid = 0;
    logic [7:0]  sh_rx_data = 0;
    logic        sh_rx_stop_ok = 1;
    logic        sh_rx_par_err = 0;
    logic        rx_line = 1;
    logic        bus_rx_rd = 0;
    logic [7:0]  bus_rx_data;
    logic [1:0]  cfg_tx_trig = 0;
    logic [1:0]  cfg_rx_trig = 0;
    logic        cfg_tx_ie = 0;
    logic        cfg_rx_ie = 0;
    logic        bus_sts_rd = 0;
    logic        bus_sts_wr = 0;
    logic [5:0]  bus_sts_wdata = 6'h3f;
    logic [5:0]  bus_sts_rdata;
    logic [15:0] bus_cnt_rdata;
    logic        tx_irq, rx_irq;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #2.5 clk = ~clk;

    uart_fifo_flags dut (
        .clk(clk), .rst(rst),
        .bus_tx_wr(bus_tx_wr), .bus_tx_data(bus_tx_data),
        .sh_tx_pop(sh_tx_pop), .sh_tx_data(sh_tx_data), .sh_tx_idle(sh_tx_idle),
        .sh_rx_valid(sh_rx_valid), .sh_rx_data(sh_rx_data),
        .sh_rx_stop_ok(sh_rx_stop_ok), .sh_rx_par_err(sh_rx_par_err),
        .rx_line(rx_line), .bus_rx_rd(bus_rx_rd), .bus_rx_data(bus_rx_data),
        .cfg_tx_trig(cfg_tx_trig), .cfg_rx_trig(cfg_rx_trig),
        .cfg_tx_ie(cfg_tx_ie), .cfg_rx_ie(cfg_rx_ie),
        .bus_sts_rd(bus_sts_rd), .bus_sts_wr(bus_sts_wr),
        .bus_sts_wdata(bus_sts_wdata), .bus_sts_rdata(bus_sts_rdata),
        .bus_cnt_rdata(bus_cnt_rdata), .tx_irq(tx_irq), .rx_irq(rx_irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic settle();
        repeat (2) @(negedge clk);
    endtask

    task automatic tx_push(input logic [7:0] d);
        @(negedge clk); bus_tx_wr = 1; bus_tx_data = d;
        @(negedge clk); bus_tx_wr = 0;
    endtask

    task automatic tx_take();
        @(negedge clk); sh_tx_pop = 1;
        @(negedge clk); sh_tx_pop = 0;
    endtask

    task automatic rx_frame(input logic [7:0] d, input logic stop, input logic perr);
        @(negedge clk);
        sh_rx_valid = 1; sh_rx_data = d; sh_rx_stop_ok = stop; sh_rx_par_err = perr;
        @(negedge clk);
        sh_rx_valid = 0; sh_rx_stop_ok = 1; sh_rx_par_err = 0;
    endtask

    task automatic rx_take();
        @(negedge clk); bus_rx_rd = 1;
        @(negedge clk); bus_rx_rd = 0;
    endtask

    task automatic sts_read();
        @(negedge clk); bus_sts_rd = 1;
        @(negedge clk); bus_sts_rd = 0;
    endtask

    task automatic sts_write(input logic [5:0] w);
        @(negedge clk); bus_sts_wr = 1; bus_sts_wdata = w;
        @(negedge clk); bus_sts_wr = 0; bus_sts_wdata = 6'h3f;
    endtask

    task automatic clear_bit(input int idx);
        sts_read();
        sts_write(~(6'b1 << idx));
    endtask

    function automatic int tx_lvl(input int code);
        return (code == 0) ? 8 : (code == 1) ? 4 : (code == 2) ? 2 : 0;
    endfunction

    function automatic int rx_lvl(input int code);
        return (code == 0) ? 1 : (code == 1) ? 4 : (code == 2) ? 8 : 14;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // Reset state
        chk("R5 reset count", bus_cnt_rdata, 0);
        chk("R1 reset status", bus_sts_rdata, 0);
        chk("R9 reset irq", {tx_irq, rx_irq}, 0);
        rst = 0;
        settle();
        chk("R1 empty tx sets space flag", bus_sts_rdata[0], 1);
        chk("R10 empty idle sets end flag", bus_sts_rdata[1], 1);
        chk("R3 empty rx keeps data flag low", bus_sts_rdata[2], 0);

        // R10 transmit end
        tx_push(8'hA5);
        chk("R10 write clears end flag", bus_sts_rdata[1], 0);
        sh_tx_idle = 0;
        tx_take();
        settle();
        chk("R10 busy shifter holds end low", bus_sts_rdata[1], 0);
        sh_tx_idle = 1;
        settle();
        chk("R10 idle and empty sets end", bus_sts_rdata[1], 1);

        // Transmit sweep: R1, R2, R5, R11
        for (int code = 0; code < 4; code++) begin
            int thr;
            cfg_tx_trig = code[1:0];
            thr = tx_lvl(code);
            settle();
            clear_bit(0);
            settle();
            chk("R2 empty after clear", bus_sts_rdata[0], 1);
            for (int n = 1; n <= 16; n++) begin
                tx_push(8'(code * 16 + n));
                settle();
                chk("R2 flag held before clear", bus_sts_rdata[0], int'((n - 1) <= thr));
                clear_bit(0);
                settle();
                chk("R2 flag after clear", bus_sts_rdata[0], int'(n <= thr));
                chk("R5 tx count upper byte", bus_cnt_rdata[15:8], n);
                chk("R5 rx count lower byte", bus_cnt_rdata[7:0], 0);
            end
            tx_push(8'hEE);
            settle();
            chk("R11 full tx drops push", bus_cnt_rdata[15:8], 16);
            for (int n = 15; n >= 0; n--) begin
                chk("R11 tx order", sh_tx_data, code * 16 + (16 - n));
                tx_take();
                settle();
                chk("R1 flag on drain", bus_sts_rdata[0], int'(n <= thr));
                clear_bit(0);
                settle();
                chk("R2 flag after clear on drain", bus_sts_rdata[0], int'(n <= thr));
            end
            tx_take();
            settle();
            chk("R11 empty tx ignores pop", bus_cnt_rdata[15:8], 0);
        end

        // Receive sweep: R3, R4, R5, R11
        for (int code = 0; code < 4; code++) begin
            int thr;
            cfg_rx_trig = code[1:0];
            thr = rx_lvl(code);
            settle();
            clear_bit(2);
            settle();
            chk("R4 empty rx after clear", bus_sts_rdata[2], 0);
            for (int n = 1; n <= 16; n++) begin
                rx_frame(8'(8'h40 + code * 16 + n), 1'b1, 1'b0);
                settle();
                chk("R3 flag on fill", bus_sts_rdata[2], int'(n >= thr));
                clear_bit(2);
                settle();
                chk("R4 flag after clear", bus_sts_rdata[2], int'(n >= thr));
                chk("R5 rx count lower byte", bus_cnt_rdata[7:0], n);
                chk("R5 tx count upper byte", bus_cnt_rdata[15:8], 0);
            end
            rx_frame(8'h11, 1'b1, 1'b0);
            settle();
            chk("R11 full rx drops frame", bus_cnt_rdata[7:0], 16);
            for (int n = 15; n >= 0; n--) begin
                chk("R11 rx order", bus_rx_data, 8'h40 + code * 16 + (16 - n));
                rx_take();
                settle();
                chk("R4 flag held before clear", bus_sts_rdata[2], int'((n + 1) >= thr));
                clear_bit(2);
                settle();
                chk("R4 flag after clear on drain", bus_sts_rdata[2], int'(n >= thr));
            end
        end

        // R6 clear protocol on the framing-error bit
        rx_frame(8'h12, 1'b0, 1'b0);
        settle();
        chk("R7 bad stop sets framing error", bus_sts_rdata[3], 1);
        chk("R7 non-zero frame still queued", bus_cnt_rdata[7:0], 1);
        sts_write(6'h00);
        settle();
        chk("R6 write without read ignored", bus_sts_rdata[3], 1);
        sts_read();
        sts_write(6'h3f);
        settle();
        chk("R6 writing one ignored", bus_sts_rdata[3], 1);
        sts_write(6'h00);
        settle();
        chk("R6 arm lost after a write", bus_sts_rdata[3], 1);
        clear_bit(3);
        settle();
        chk("R6 read then write zero clears", bus_sts_rdata[3], 0);
        rx_take();

        // R7 parity
        rx_frame(8'h21, 1'b1, 1'b1);
        settle();
        chk("R7 parity error sets bit 4", bus_sts_rdata[4], 1);
        rx_take();
        clear_bit(4);
        settle();
        chk("R7 parity bit clears", bus_sts_rdata[4], 0);

        // R7/R8 break handling
        rx_line = 0;
        rx_frame(8'h00, 1'b0, 1'b1);
        settle();
        chk("R7 break sets framing error", bus_sts_rdata[3], 1);
        chk("R7 break sets break bit", bus_sts_rdata[5], 1);
        chk("R7 break frame parity flag", bus_sts_rdata[4], 1);
        chk("R8 break frame not queued", bus_cnt_rdata[7:0], 0);
        rx_frame(8'h55, 1'b1, 1'b0);
        settle();
        chk("R8 frame during break not queued", bus_cnt_rdata[7:0], 0);
        rx_line = 1;
        settle();
        rx_frame(8'h33, 1'b1, 1'b0);
        settle();
        chk("R8 queueing resumes after line high", bus_cnt_rdata[7:0], 1);
        chk("R8 resumed byte value", bus_rx_data, 8'h33);

        // R9 interrupts (rx count 1, code 3 level 14 -> use code 0)
        cfg_rx_trig = 2'b00;
        settle();
        @(negedge clk);
        cfg_tx_ie = 1;
        chk("R9 tx irq not yet", tx_irq, 0);
        @(negedge clk);
        chk("R9 tx irq one cycle later", tx_irq, 1);
        cfg_tx_ie = 0;
        @(negedge clk);
        chk("R9 tx irq drops with enable", tx_irq, 0);
        cfg_rx_ie = 1;
        @(negedge clk);
        chk("R9 rx irq follows flag", rx_irq, 1);
        rx_take();
        clear_bit(2);
        settle();
        chk("R9 rx irq drops with flag", rx_irq, 0);
        cfg_rx_ie = 0;

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule